// File: doc/BRIEF.md
# Generation-bit circular event queue

This block is a ring of event words held in local storage. A producer posts nonzero event numbers of 31 bits. Each number is written with the producer's current generation bit in the top bit of the 32-bit slot, and the producer flips that bit every time its write index wraps. The consumer does not compare a head pointer against a tail pointer to find out whether data is present. It looks only at the slot under its own read index. When the slot's generation bit equals the consumer's toggle bit, the slot is stale and the queue is empty. The consumer toggle flips every time the read index wraps. After reset the ring is all zeros, the consumer toggle is 0 and the producer generation is 1, so the queue starts out empty.

The consumer can ask for two kinds of read. A pop returns the payload and moves the read index forward. A peek returns the same payload and leaves the read index and the toggle unchanged. A read of an empty queue returns zero, so zero is reserved to mean "no event" and a posted zero is discarded. When every slot holds an unread event, another post is dropped and the block raises an overflow flag for one cycle.

Top module: `gen_evt_queue`

## Requirements
- R1: After reset, evt_o and ovf_o are 0, and a peek or pop issued before any post returns 0.
- R2: An accepted post stores {generation, event} at the write index: bit 31 holds the generation bit and bits 30:0 hold the event. The write index then advances modulo DEPTH, and the generation bit inverts when the index wraps to 0.
- R3: A pop or peek of a slot whose bit 31 equals the consumer toggle returns 0 on evt_o in the next cycle. The read index does not move.
- R4: A pop of a filled slot presents its 31-bit event on evt_o in the next cycle. The read index advances by one modulo DEPTH, so events come out in posting order.
- R5: The consumer toggle inverts when the read index wraps to 0, so events stay correct across any number of laps of the ring.
- R6: A peek presents the same event that a pop would return, and leaves the read index and toggle unchanged.
- R7: When pop_i and peek_i are both high, the request acts as a pop.
- R8: A post made while DEPTH events are unread is dropped, ovf_o is high for the following cycle, and the queued events are untouched.
- R9: A post whose event is 0 is ignored. Nothing is written and ovf_o stays low.
- R10: In a cycle with neither pop_i nor peek_i, evt_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| post_i | input | 1 | Post request |
| post_evt_i | input | 31 | Event number to post (nonzero) |
| ovf_o | output | 1 | One-cycle pulse after a dropped post |
| pop_i | input | 1 | Consuming read request |
| peek_i | input | 1 | Non-consuming read request |
| evt_o | output | 31 | Read result, registered; 0 means empty |

## Verification
The assertions take for granted that DEPTH is a power of two and that requests arrive as single-cycle levels sampled at the rising edge. They make no assumption about how pops and posts interleave. The scoreboard stimulus posts only nonzero events, except where R9 is exercised on purpose. It mixes back-to-back posts and pops so that both indices wrap several times. It drives the ring to exactly DEPTH unread events before it posts one more.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int unsigned EVT_W = 31;
  typedef logic [EVT_W-1:0] evt_t;
  typedef struct packed {
    logic gen;
    evt_t evt;
  } evq_entry_t;
endpackage

// File: rtl/evq_ram.sv
module evq_ram
  import evq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  evq_entry_t       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output evq_entry_t       rdata_o
);
  evq_entry_t mem [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem[s] <= '0;
      else if (we_i && waddr_i == IDX_W'(s))          mem[s] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/evq_prod.sv
module evq_prod
  import evq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             post_i,
  input  evt_t             evt_i,
  input  logic             full_i,
  output logic             we_o,
  output logic [IDX_W-1:0] waddr_o,
  output evq_entry_t       wdata_o,
  output logic             gen_o,
  output logic             ovf_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] widx_q;
  logic             gen_q, ovf_q;
  logic             valid_post, accept, drop;

  assign valid_post = post_i && (evt_i != '0);
  assign accept     = valid_post && !full_i;
  assign drop       = valid_post && full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_q <= '0;
      gen_q  <= 1'b1;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= drop;
      if (accept) begin
        widx_q <= widx_q + 1'b1;
        if (widx_q == LAST) gen_q <= ~gen_q;
      end
    end
  end

  assign we_o        = accept;
  assign waddr_o     = widx_q;
  assign wdata_o.gen = gen_q;
  assign wdata_o.evt = evt_i;
  assign gen_o       = gen_q;
  assign ovf_o       = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_i && evt_i != '0 && full_i) |=> ($stable(waddr_o) && $stable(gen_o) && ovf_o)); // R8
  AST_ZERO_POST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_i && evt_i == '0) |=> ($stable(waddr_o) && !ovf_o)); // R9
  AST_GEN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_i && evt_i != '0 && !full_i && waddr_o == LAST) |=> (waddr_o == '0 && gen_o != $past(gen_o))); // R2
endmodule

// File: rtl/evq_cons.sv
module evq_cons
  import evq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_i,
  input  logic             peek_i,
  input  evq_entry_t       ent_i,
  output logic [IDX_W-1:0] raddr_o,
  output logic             tog_o,
  output evt_t             evt_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ridx_q;
  logic             tog_q, stale;
  evt_t             evt_q;

  // slot is stale when its generation matches our toggle
  assign stale = (ent_i.gen == tog_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ridx_q <= '0;
      tog_q  <= 1'b0;
      evt_q  <= '0;
    end else begin
      if (pop_i || peek_i) evt_q <= stale ? '0 : ent_i.evt;
      if (pop_i && !stale) begin
        ridx_q <= ridx_q + 1'b1;
        if (ridx_q == LAST) tog_q <= ~tog_q;
      end
    end
  end

  assign raddr_o = ridx_q;
  assign tog_o   = tog_q;
  assign evt_o   = evt_q;

  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pop_i || peek_i) && ent_i.gen == tog_o) |=> (evt_o == '0 && $stable(raddr_o))); // R3
  AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && ent_i.gen != tog_o && raddr_o != LAST) |=> (raddr_o == $past(raddr_o) + IDX_W'(1))); // R4
  AST_TOG_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && ent_i.gen != tog_o && raddr_o == LAST) |=> (raddr_o == '0 && tog_o != $past(tog_o))); // R5
  AST_PEEK_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peek_i && !pop_i) |=> ($stable(raddr_o) && $stable(tog_o))); // R6
  AST_EVT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i || peek_i) |=> $stable(evt_o)); // R10
endmodule

// File: rtl/gen_evt_queue.sv
module gen_evt_queue
  import evq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        post_i,
  input  logic [30:0] post_evt_i,
  output logic        ovf_o,
  input  logic        pop_i,
  input  logic        peek_i,
  output logic [30:0] evt_o
);
  logic             we, gen, tog, full;
  logic [IDX_W-1:0] waddr, raddr;
  evq_entry_t       wdata, rdata;

  // ring holds DEPTH unread events when the producer sits one full lap ahead
  assign full = (waddr == raddr) && (gen == tog);

  evq_prod #(.DEPTH(DEPTH)) u_prod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .post_i  (post_i),
    .evt_i   (post_evt_i),
    .full_i  (full),
    .we_o    (we),
    .waddr_o (waddr),
    .wdata_o (wdata),
    .gen_o   (gen),
    .ovf_o   (ovf_o)
  );

  evq_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  evq_cons #(.DEPTH(DEPTH)) u_cons (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pop_i   (pop_i),
    .peek_i  (peek_i),
    .ent_i   (rdata),
    .raddr_o (raddr),
    .tog_o   (tog),
    .evt_o   (evt_o)
  );

  AST_FULL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we && full)); // R8
endmodule

// File: tb/gen_evt_queue_bench.sv
`timescale 1ns/1ps
module gen_evt_queue_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        post_i = 1'b0;
  logic [30:0] post_evt_i = '0;
  logic        pop_i = 1'b0;
  logic        peek_i = 1'b0;
  logic        ovf_o;
  logic [30:0] evt_o;

  int total = 0;
  int bad = 0;
  logic [30:0] exp_q [$];

  always #2 clk = ~clk;

  gen_evt_queue #(.DEPTH(DEPTH)) u_gen_evt_queue (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .post_i     (post_i),
    .post_evt_i (post_evt_i),
    .ovf_o      (ovf_o),
    .pop_i      (pop_i),
    .peek_i     (peek_i),
    .evt_o      (evt_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at a negedge
  task automatic post(input logic [30:0] v, input string req);
    bit exp_ovf;
    exp_ovf = (v != '0) && (exp_q.size() == DEPTH);
    if (v != '0 && !exp_ovf) exp_q.push_back(v);
    post_i = 1'b1; post_evt_i = v;
    @(negedge clk);
    post_i = 1'b0; post_evt_i = '0;
    check(ovf_o == exp_ovf, req, {31'd0, ovf_o}, {31'd0, exp_ovf});
  endtask

  // monitor side: pop or peek, compare with scoreboard head
  task automatic read(input bit do_pop, input bit do_peek, input string req);
    logic [30:0] exp;
    exp = (exp_q.size() != 0) ? exp_q[0] : '0;
    if (do_pop && exp_q.size() != 0) void'(exp_q.pop_front());
    pop_i = do_pop; peek_i = do_peek;
    @(negedge clk);
    pop_i = 1'b0; peek_i = 1'b0;
    check(evt_o == exp, req, {1'b0, evt_o}, {1'b0, exp});
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [30:0] held;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(evt_o == '0 && ovf_o == 1'b0, "R1", {ovf_o, evt_o}, 32'd0);
    read(1'b0, 1'b1, "R1 peek after reset");
    read(1'b1, 1'b0, "R1 pop after reset");
    // R9 zero post ignored
    post('0, "R9 zero post no ovf");
    read(1'b0, 1'b1, "R9 zero post not stored");
    // R2/R4/R6 basic order
    post(31'h11, "R2"); post(31'h7fffffff, "R2"); post(31'h33, "R2");
    read(1'b0, 1'b1, "R6 peek");
    read(1'b0, 1'b1, "R6 peek again");
    read(1'b1, 1'b0, "R4 pop");
    read(1'b1, 1'b0, "R4 pop max payload");
    // R10 hold
    held = evt_o;
    @(negedge clk); @(negedge clk);
    check(evt_o == held, "R10 hold", {1'b0, evt_o}, {1'b0, held});
    // R7 both requests act as pop
    read(1'b1, 1'b1, "R7 pop wins");
    read(1'b1, 1'b0, "R3 pop empty");
    read(1'b0, 1'b1, "R3 peek empty");
    // R8 fill ring then overflow
    for (int i = 0; i < DEPTH; i++) post(31'h100 + 31'(i), "R8 fill");
    post(31'h5a5, "R8 overflow");
    post(31'h5a6, "R8 overflow again");
    for (int i = 0; i < DEPTH; i++) read(1'b1, 1'b0, "R8 contents kept");
    read(1'b1, 1'b0, "R3 empty after drain");
    // R5 several laps
    for (int i = 0; i < 4 * DEPTH; i++) begin
      post(31'h2000 + 31'(i), "R5 post");
      post(31'h4000 + 31'(i), "R5 post");
      read(1'b1, 1'b0, "R5 pop");
      if (i % 3 == 0) read(1'b1, 1'b0, "R5 pop");
      if (exp_q.size() >= DEPTH - 1) begin
        while (exp_q.size() != 0) read(1'b1, 1'b0, "R5 drain");
      end
    end
    while (exp_q.size() != 0) read(1'b1, 1'b0, "R5 final drain");
    read(1'b0, 1'b1, "R3 empty after laps");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule